// File: doc/BRIEF.md
# MII Receive Frame Capture Buffer

This block takes the receive side of a media-independent interface (a receive clock, a data-valid line and a 4-bit data bus) and records one Ethernet frame at a time into an on-chip byte buffer. It does not use the PHY receive clock as a clock. All three inputs are oversampled by a faster system clock. A rising edge of the receive clock, seen in the sampled stream, marks the moment to take one nibble. Because of this, the same logic works at the 25 MHz nibble rate of a 100 Mbit/s link and at the 2.5 MHz nibble rate of a 10 Mbit/s link, with no setting to change.

Qualified nibbles are paired into bytes and written to consecutive buffer addresses starting at zero. When the data-valid line drops, the block records the byte count and raises a ready flag. While that flag is up, further frames are ignored. A downstream consumer, such as a serial sender, reads the bytes through a simple address/data port. It then pulses a clear input to arm capture for the next frame.

Top module: `mii_rx_capture`

## Requirements
- R1: After reset, frame_ready_o is 0, overflow_o is 0 and frame_len_o is 0.
- R2: Bytes of a captured frame are stored at addresses 0, 1, 2, … in arrival order. Within each byte, the first nibble received forms bits 3:0 and the second nibble forms bits 7:4.
- R3: A nibble is taken only at a rising edge of the receive clock while data-valid is high. Receive clock edges with data-valid low store nothing and do not change the length.
- R4: When data-valid falls at the end of an accepted frame, frame_len_o takes the number of complete bytes and frame_ready_o rises within 6 system clocks. A final unpaired nibble is discarded.
- R5: While frame_ready_o is 1 and clear_i is low, a new frame on the interface changes neither the buffer contents, nor frame_len_o, nor frame_ready_o.
- R6: A one-cycle pulse on clear_i makes frame_ready_o 0 on the next clock. The next frame whose data-valid rises after that is captured.
- R7: The buffer holds 2^ADDR_W bytes (2048 by default). Bytes beyond the last address are dropped, overflow_o is set and frame_len_o reports 2048. overflow_o returns to 0 when the next frame is accepted.
- R8: rd_data_o gives the byte at rd_addr_i one system clock after the address is presented.
- R9: Capture gives identical results at a fast nibble rate (8 system clocks per nibble) and at a rate ten times slower (80 system clocks per nibble).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_clk_i | input | 1 | PHY receive clock, sampled as data |
| rx_dv_i | input | 1 | PHY receive data-valid |
| rx_data_i | input | 4 | PHY receive nibble |
| clear_i | input | 1 | Releases the captured frame and arms capture |
| rd_addr_i | input | ADDR_W | Buffer read address |
| rd_data_o | output | 8 | Byte at the read address, one clock later |
| frame_ready_o | output | 1 | A complete frame is held in the buffer |
| frame_len_o | output | ADDR_W+1 | Byte count of the held frame |
| overflow_o | output | 1 | The current or last frame exceeded the buffer |

## Verification
A wrong pairing state (a stale low nibble, or a phase that is off by one) shows up at once in the first byte read back: its nibbles appear swapped or shifted against the bench reference, and frame_len_o differs by one on odd-length frames. A wrong edge detector, one that fires twice or misses an edge, corrupts every later byte and changes the length. This is seen at the first readout after data-valid falls. Faults in the ready and write-count state show up as a length that changes or a buffer that is overwritten while a frame is held. They also show up as an overflow flag that is wrong after a frame 3 bytes longer than the buffer.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

    // One sample of the receive-side pins taken on the system clock
    typedef struct packed {
        logic       rclk;
        logic       dv;
        logic [3:0] nib;
    } mii_sample_t;

endpackage

// File: rtl/mii_rx_sync.sv
module mii_rx_sync
    import mii_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_clk_i,
    input  logic       rx_dv_i,
    input  logic [3:0] rx_data_i,
    output logic       edge_o,
    output logic       dv_o,
    output logic [3:0] nib_o
);

    typedef struct packed {
        mii_sample_t meta;
        mii_sample_t stab;
        mii_sample_t dly;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        s_d.meta.rclk = rx_clk_i;
        s_d.meta.dv   = rx_dv_i;
        s_d.meta.nib  = rx_data_i;
        s_d.stab      = s_q.meta;
        s_d.dly       = s_q.stab;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Edge seen between stab and dly; data comes from dly, the sample taken
    // before the edge became visible, so it is clear of the transition.
    assign edge_o = s_q.stab.rclk & ~s_q.dly.rclk;
    assign dv_o   = s_q.dly.dv;
    assign nib_o  = s_q.dly.nib;

endmodule

// File: rtl/mii_rx_assembler.sv
module mii_rx_assembler #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_i,
    input  logic              dv_i,
    input  logic [3:0]        nib_i,
    input  logic              clear_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_byte_o,
    output logic              ready_o,
    output logic [ADDR_W:0]   len_o,
    output logic              ovf_o
);

    typedef struct packed {
        logic            dv_last;
        logic            in_frame;
        logic            have_low;
        logic [3:0]      low;
        logic [ADDR_W:0] count;
        logic            ready;
        logic [ADDR_W:0] len;
        logic            ovf;
    } asm_t;

    asm_t a_d, a_q;

    logic            accept;
    logic            active;
    logic            hl;
    logic [ADDR_W:0] cnt;

    always_comb begin
        a_d         = a_q;
        wr_en_o     = 1'b0;
        accept      = dv_i & ~a_q.dv_last & ~a_q.ready;
        active      = a_q.in_frame | accept;
        hl          = accept ? 1'b0 : a_q.have_low;
        cnt         = accept ? '0 : a_q.count;
        a_d.dv_last = dv_i;

        if (accept) begin
            a_d.in_frame = 1'b1;
            a_d.ovf      = 1'b0;
        end

        a_d.have_low = hl;
        a_d.count    = cnt;

        if (active && edge_i && dv_i) begin
            if (!hl) begin
                a_d.low      = nib_i;
                a_d.have_low = 1'b1;
            end else begin
                a_d.have_low = 1'b0;
                if (!cnt[ADDR_W]) begin
                    wr_en_o   = 1'b1;
                    a_d.count = cnt + 1'b1;
                end else begin
                    a_d.ovf = 1'b1;
                end
            end
        end

        if (a_q.in_frame && !dv_i && a_q.dv_last) begin
            a_d.len      = a_q.count;
            a_d.ready    = 1'b1;
            a_d.in_frame = 1'b0;
            a_d.have_low = 1'b0;
        end

        if (clear_i) a_d.ready = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign wr_addr_o = cnt[ADDR_W-1:0];
    assign wr_byte_o = {nib_i, a_q.low};
    assign ready_o   = a_q.ready;
    assign len_o     = a_q.len;
    assign ovf_o     = a_q.ovf;

endmodule

// File: rtl/mii_rx_buffer.sv
module mii_rx_buffer #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
        rd_q <= mem[rd_addr_i];
    end

    assign rd_data_o = rd_q;

endmodule

// File: rtl/mii_rx_capture.sv
module mii_rx_capture #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_clk_i,
    input  logic              rx_dv_i,
    input  logic [3:0]        rx_data_i,
    input  logic              clear_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic              frame_ready_o,
    output logic [ADDR_W:0]   frame_len_o,
    output logic              overflow_o
);

    logic              edge_stb;
    logic              dv_s;
    logic [3:0]        nib_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_byte;

    mii_rx_sync sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_clk_i  (rx_clk_i),
        .rx_dv_i   (rx_dv_i),
        .rx_data_i (rx_data_i),
        .edge_o    (edge_stb),
        .dv_o      (dv_s),
        .nib_o     (nib_s)
    );

    mii_rx_assembler #(.ADDR_W(ADDR_W)) asm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (edge_stb),
        .dv_i      (dv_s),
        .nib_i     (nib_s),
        .clear_i   (clear_i),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_byte_o (wr_byte),
        .ready_o   (frame_ready_o),
        .len_o     (frame_len_o),
        .ovf_o     (overflow_o)
    );

    mii_rx_buffer #(.ADDR_W(ADDR_W), .DATA_W(8)) buf_i (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_byte),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: rtl/mii_rx_capture_chk.sv
module mii_rx_capture_chk #(
    parameter int ADDR_W = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic            clear_i,
    input logic            frame_ready_o,
    input logic [ADDR_W:0] frame_len_o,
    input logic            strobe
);

    localparam int DEPTH = 1 << ADDR_W;

    // R9: an oversampled edge strobe never lasts two cycles
    p_strobe_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R5: a held frame keeps its flag and length until cleared
    p_ready_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ready_o && !clear_i) |=> (frame_ready_o && $stable(frame_len_o)));

    // R6: clear drops the ready flag on the next clock
    p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !frame_ready_o);

    // R7: a reported length never exceeds the buffer size
    p_len_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ready_o |-> (frame_len_o <= (ADDR_W+1)'(DEPTH)));

endmodule

bind mii_rx_capture mii_rx_capture_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_i       (clear_i),
    .frame_ready_o (frame_ready_o),
    .frame_len_o   (frame_len_o),
    .strobe        (edge_stb)
);

// File: tb/mii_rx_capture_tb_top.sv
`timescale 1ns/1ps
module mii_rx_capture_tb_top;

    localparam int ADDR_W = 11;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_clk = 1'b0;
    logic              rx_dv = 1'b0;
    logic [3:0]        rx_data = 4'h0;
    logic              clear = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;
    logic              ready;
    logic [ADDR_W:0]   len;
    logic              ovf;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_mem [0:DEPTH-1];
    int exp_len;
    logic [3:0] prev_nib;

    always #2.5 clk = ~clk;

    mii_rx_capture #(.ADDR_W(ADDR_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_clk_i      (rx_clk),
        .rx_dv_i       (rx_dv),
        .rx_data_i     (rx_data),
        .clear_i       (clear),
        .rd_addr_i     (rd_addr),
        .rd_data_o     (rd_data),
        .frame_ready_o (ready),
        .frame_len_o   (len),
        .overflow_o    (ovf)
    );

    function automatic int exp_bytes(input int nnib);
        int b = nnib / 2;
        return (b > DEPTH) ? DEPTH : b;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic nibble(input logic [3:0] n, input logic dv, input int h);
        @(negedge clk);
        rx_clk  = 1'b0;
        rx_data = n;
        rx_dv   = dv;
        repeat (h) @(negedge clk);
        rx_clk = 1'b1;
        repeat (h - 1) @(negedge clk);
    endtask

    // Sends nnib nibbles; when rec is set the reference image is rebuilt
    task automatic send_frame(input int nnib, input int h, input bit rec);
        logic [3:0] n;
        for (int i = 0; i < nnib; i++) begin
            n = 4'($urandom);
            if (rec && (i % 2 == 1) && (i / 2 < DEPTH))
                exp_mem[i / 2] = {n, prev_nib};
            prev_nib = n;
            nibble(n, 1'b1, h);
        end
        if (rec) exp_len = exp_bytes(nnib);
        nibble(4'($urandom), 1'b0, h);
        @(negedge clk);
        rx_clk = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic rd_byte(input int a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = ADDR_W'(a);
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic pulse_clear;
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    task automatic check_bytes(input string req, input int n);
        logic [7:0] d;
        int bad = 0;
        int first_a = 0;
        int first_e = 0;
        for (int a = 0; a < n; a++) begin
            rd_byte(a, d);
            if (d !== exp_mem[a]) begin
                if (bad == 0) begin
                    first_a = int'(d);
                    first_e = int'(exp_mem[a]);
                end
                bad++;
            end
        end
        check(bad == 0, req, first_a, first_e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int nn;
        int hh;
        void'($urandom(32'd1234));
        prev_nib = 4'h0;
        exp_len  = 0;
        repeat (5) @(negedge clk);
        check(ready === 1'b0, "R1 ready", int'(ready), 0);
        check(ovf === 1'b0, "R1 overflow", int'(ovf), 0);
        check(len === '0, "R1 length", int'(len), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: receive clock edges with data-valid low store nothing
        for (int i = 0; i < 6; i++) nibble(4'($urandom), 1'b0, 4);
        check(ready === 1'b0, "R3 idle edges", int'(ready), 0);

        // R2 / R4: even frame at the fast rate
        send_frame(40, 4, 1'b1);
        check(ready === 1'b1, "R4 ready after frame", int'(ready), 1);
        check(int'(len) == exp_len, "R3 length counts valid pairs", int'(len), exp_len);
        check_bytes("R2 byte order", exp_len);

        // R8: byte appears one clock after address
        @(negedge clk);
        rd_addr = ADDR_W'(3);
        @(negedge clk);
        check(rd_data === exp_mem[3], "R8 read latency", int'(rd_data), int'(exp_mem[3]));

        // R5: a second frame while held is ignored
        begin
            logic [7:0] keep0;
            keep0 = exp_mem[0];
            send_frame(20, 4, 1'b0);
            check(ready === 1'b1, "R5 ready held", int'(ready), 1);
            check(int'(len) == exp_len, "R5 length held", int'(len), exp_len);
            rd_byte(0, d);
            check(d === keep0, "R5 buffer untouched", int'(d), int'(keep0));
        end

        // R6: clear drops ready on the next clock
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        check(ready === 1'b0, "R6 clear", int'(ready), 0);

        // R9 / R4: odd frame at the slow rate, last nibble discarded
        send_frame(33, 40, 1'b1);
        check(ready === 1'b1, "R6 rearmed capture", int'(ready), 1);
        check(int'(len) == 16, "R4 odd nibble dropped", int'(len), 16);
        check_bytes("R9 slow rate bytes", exp_len);

        // Random frames at both rates
        for (int k = 0; k < 6; k++) begin
            pulse_clear();
            nn = 2 + int'($urandom_range(118));
            hh = ($urandom_range(1) == 1) ? 40 : 4;
            send_frame(nn, hh, 1'b1);
            check(int'(len) == exp_len, "R9 random length", int'(len), exp_len);
            check_bytes("R2 random bytes", exp_len);
        end

        // R7: overflow
        pulse_clear();
        send_frame(2 * DEPTH + 6, 4, 1'b1);
        check(ovf === 1'b1, "R7 overflow set", int'(ovf), 1);
        check(int'(len) == DEPTH, "R7 length saturates", int'(len), DEPTH);
        rd_byte(0, d);
        check(d === exp_mem[0], "R7 first byte", int'(d), int'(exp_mem[0]));
        rd_byte(DEPTH - 1, d);
        check(d === exp_mem[DEPTH-1], "R7 last byte", int'(d), int'(exp_mem[DEPTH-1]));
        pulse_clear();
        send_frame(8, 4, 1'b1);
        check(ovf === 1'b0, "R7 overflow cleared", int'(ovf), 0);
        check(int'(len) == 4, "R7 short frame after", int'(len), 4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule